// File: doc/BRIEF.md
# Selectable 8 kHz Reference Generator

This block builds a global 8 kHz reference strobe and a one-second tick. A 3-bit select code picks the source. The candidates are three line-rate clocks, each brought down to 8 kHz by its own integer divider, and four per-port 8 kHz references. An override bit replaces all of them with an external 8 kHz input pin. The chosen level is brought into the system clock domain and its rising edges become single-cycle strobes. A counter on the system clock counts those strobes and marks each full second.

Each line-rate clock can come from one of two places: the output of a clock-recovery stage, or an alternate clock input pin. One enable input makes that choice. An output-select bit can send the strobe out on a shared general-purpose pin. A soft-reset input returns all internal state to its defaults. The control inputs are expected to come from a register in the system clock domain.

Top module: `refgen_8k`

## Requirements
- R1: While the hard reset `rst_n` is low, `ref_strobe` and `sec_tick` are 0, and `gpio_o` follows `gpio_alt`.
- R2: When the override is 0 and the select code is 000, the selected level is constant 0. No strobe is produced and the second counter is held at zero.
- R3: With the override at 0, codes 001, 010 and 011 select divider 0, 1 and 2. These are clocked from line clock 0, 1 and 2, with ratios DIV_DS3, DIV_E3 and DIV_STS1. Each line clock is `rec_clk[i]` when `clk_rec_en` is 1 and `pin_clk[i]` when it is 0. Strobes then repeat once per divider period.
- R4: With the override at 0, codes 100, 101, 110 and 111 select `port_ref[0]`, `port_ref[1]`, `port_ref[2]` and `port_ref[3]`. Suppose the selected level is first sampled high at a clock edge k after being sampled low at edge k-1. Then `ref_strobe` is high for exactly the cycle that follows edge k+2.
- R5: When `ref_in_sel` is 1, `ext_ref` is the source whatever the select code is, including 000. When `ref_in_sel` is 0, `ext_ref` has no effect on any output.
- R6: `sec_tick` goes high for one cycle after the clock edge at which the SEC_STROBES-th strobe since the last clear is counted. The count then wraps to zero.
- R7: The second counter is cleared, and no tick is given, at any clock edge where the effective source code differs from its value at the previous edge, or where the source is none. The effective code is the override bit together with the select code, and the select code is ignored while the override is set.
- R8: When `ref_out_sel` is 1, `gpio_o` equals `ref_strobe`. When it is 0, `gpio_o` equals `gpio_alt`.
- R9: While `soft_rst` is 1, `ref_strobe` and `sec_tick` stay 0, the second counter and the edge-detector stages clear, and the dividers are restarted through a synchronizer in their own clock domain. After release, divided strobes resume at their normal period.
- R10: A selected level that rises once and stays high produces exactly one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Register-driven soft reset, active high |
| sel | input | 3 | Source select code |
| ref_in_sel | input | 1 | Override: use the external reference pin |
| ref_out_sel | input | 1 | Send the strobe out on the shared pin |
| clk_rec_en | input | 1 | 1: recovered clocks drive the dividers; 0: alternate pin clocks |
| rec_clk | input | 3 | Recovered line-rate clocks (index 0, 1, 2 for the three rates) |
| pin_clk | input | 3 | Alternate line-rate clock pins |
| port_ref | input | 4 | Per-port 8 kHz reference levels |
| ext_ref | input | 1 | External 8 kHz reference pin |
| gpio_alt | input | 1 | Value the shared pin carries in its normal mode |
| gpio_o | output | 1 | Shared general-purpose pin output |
| ref_strobe | output | 1 | One-cycle 8 kHz strobe in the system domain |
| sec_tick | output | 1 | One-cycle one-second tick |

## Verification
The assertions take the control inputs as register outputs that are already synchronous to `clk`. Only the reference levels and the line clocks are treated as asynchronous. They also take `soft_rst` as held long enough for each line domain to capture it. The bench therefore changes the control bits only just after a falling system edge and holds the soft reset for twelve system cycles. The line clocks run at fixed multiples of the system period with a constant phase offset from it. This keeps divided strobe spacing exact, so intervals can be compared to the cycle.

// File: rtl/refgen_pkg.sv
`timescale 1ns/1ps
package refgen_pkg;

    // effective source code: bit 3 = external override, bits 2:0 = select
    localparam logic [3:0] CODE_IDLE = 4'b0000;
    localparam logic [3:0] CODE_EXT  = 4'b1000;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_LINE,
        SRC_PORT,
        SRC_EXT
    } src_kind_e;

    function automatic logic [3:0] eff_code(input logic ovr, input logic [2:0] sel);
        return ovr ? CODE_EXT : {1'b0, sel};
    endfunction

    function automatic src_kind_e src_kind(input logic [3:0] code);
        if (code[3])
            return SRC_EXT;
        else if (code[2])
            return SRC_PORT;
        else if (code[1:0] != 2'b00)
            return SRC_LINE;
        else
            return SRC_NONE;
    endfunction

endpackage

// File: rtl/refgen_div.sv
`timescale 1ns/1ps
// Line-rate divider: runs in its own clock domain, emits a square wave
// whose rising edge repeats every DIV input cycles.
module refgen_div #(
    parameter int DIV = 5592
) (
    input  logic lclk,
    input  logic rst_n,
    input  logic soft_rst,
    output logic lvl_o
);
    localparam int W    = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;
    localparam logic [W-1:0] LAST  = W'(DIV - 1);
    localparam logic [W-1:0] HALFW = W'(HALF);

    typedef struct packed {
        logic [1:0]   rs;   // soft reset synchronizer into lclk domain
        logic [W-1:0] cnt;
        logic         lvl;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [W-1:0] nxt;

    always_comb begin
        st_d    = st_q;
        st_d.rs = {st_q.rs[0], soft_rst};
        nxt     = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        if (st_q.rs[1]) begin
            st_d.cnt = '0;
            st_d.lvl = 1'b0;
        end else begin
            st_d.cnt = nxt;
            st_d.lvl = (nxt < HALFW);
        end
    end

    always_ff @(posedge lclk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign lvl_o = st_q.lvl;

    AST_DIV_SRST: assert property (@(posedge lclk) disable iff (!rst_n)
        st_q.rs[1] |=> (st_q.cnt == '0 && !st_q.lvl)); // R9

endmodule

// File: rtl/refgen_edge.sv
`timescale 1ns/1ps
// Two-flop synchronizer plus rising-edge detector, registered strobe.
module refgen_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic lvl_i,
    output logic strobe_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
        logic strobe;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        if (soft_rst) begin
            st_d = '0;
        end else begin
            st_d.s1     = lvl_i;
            st_d.s2     = st_q.s1;
            st_d.s3     = st_q.s2;
            st_d.strobe = st_q.s2 & ~st_q.s3;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign strobe_o = st_q.strobe;

    AST_STROBE_FROM_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> $past(lvl_i, 3)); // R4

    AST_SRST_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !strobe_o); // R9

endmodule

// File: rtl/refgen_sec.sv
`timescale 1ns/1ps
// One-second counter: counts strobes, ticks on the last one, wraps.
module refgen_sec #(
    parameter int STROBES = 8000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic clr,
    input  logic strobe_i,
    output logic tick_o
);
    localparam int CW = (STROBES > 2) ? $clog2(STROBES) : 1;
    localparam logic [CW-1:0] LAST = CW'(STROBES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } sec_st_t;

    sec_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (soft_rst || clr) begin
            st_d.cnt = '0;
        end else if (strobe_i) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    AST_TICK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> $past(strobe_i)); // R6

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0 && !tick_o)); // R7

    AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (st_q.cnt == '0 && !tick_o)); // R9

endmodule

// File: rtl/refgen_8k.sv
`timescale 1ns/1ps
module refgen_8k
    import refgen_pkg::*;
#(
    parameter int DIV_DS3     = 5592,
    parameter int DIV_E3      = 4296,
    parameter int DIV_STS1    = 6480,
    parameter int SEC_STROBES = 8000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic [2:0] sel,
    input  logic       ref_in_sel,
    input  logic       ref_out_sel,
    input  logic       clk_rec_en,
    input  logic [2:0] rec_clk,
    input  logic [2:0] pin_clk,
    input  logic [3:0] port_ref,
    input  logic       ext_ref,
    input  logic       gpio_alt,
    output logic       gpio_o,
    output logic       ref_strobe,
    output logic       sec_tick
);
    localparam int NLINE = 3;

    typedef struct packed {
        logic [3:0] code;   // effective source code seen at the last edge
    } top_st_t;

    top_st_t     st_d, st_q;
    logic [NLINE-1:0] line_clk;
    logic [NLINE-1:0] line_lvl;
    logic [3:0]  code_now;
    src_kind_e   kind;
    logic        ext_int;
    logic        sel_lvl;
    logic        clr;
    logic        strobe;
    logic        tick;

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        localparam int RATIO = (g == 0) ? DIV_DS3 : (g == 1) ? DIV_E3 : DIV_STS1;
        assign line_clk[g] = clk_rec_en ? rec_clk[g] : pin_clk[g];
        refgen_div #(.DIV(RATIO)) u_div (
            .lclk     (line_clk[g]),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .lvl_o    (line_lvl[g])
        );
    end

    always_comb begin
        code_now = eff_code(ref_in_sel, sel);
        kind     = src_kind(code_now);
        ext_int  = ref_in_sel & ext_ref;   // pin held low unless selected
        unique case (kind)
            SRC_LINE: sel_lvl = line_lvl[code_now[1:0] - 2'd1];
            SRC_PORT: sel_lvl = port_ref[code_now[1:0]];
            SRC_EXT:  sel_lvl = ext_int;
            default:  sel_lvl = 1'b0;
        endcase
        clr       = (code_now != st_q.code) || (kind == SRC_NONE);
        st_d.code = soft_rst ? CODE_IDLE : code_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    refgen_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .lvl_i    (sel_lvl),
        .strobe_o (strobe)
    );

    refgen_sec #(.STROBES(SEC_STROBES)) u_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .clr      (clr),
        .strobe_i (strobe),
        .tick_o   (tick)
    );

    assign ref_strobe = strobe;
    assign sec_tick   = tick;
    assign gpio_o     = ref_out_sel ? strobe : gpio_alt;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(kind == SRC_NONE, 3) |-> !ref_strobe); // R2

endmodule

// File: tb/refgen_8k_test.sv
`timescale 1ns/1ps
module refgen_8k_test;
    localparam int D0 = 6;
    localparam int D1 = 5;
    localparam int D2 = 4;
    localparam int NS = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       ref_in_sel = 1'b0;
    logic       ref_out_sel = 1'b0;
    logic       clk_rec_en = 1'b0;
    logic       pc0 = 1'b0, pc1 = 1'b0, pc2 = 1'b0;
    logic       rc0 = 1'b0, rc1 = 1'b0, rc2 = 1'b0;
    logic [2:0] rec_clk;
    logic [2:0] pin_clk;
    logic [3:0] port_ref = 4'd0;
    logic       ext_ref = 1'b0;
    logic       gpio_alt = 1'b0;
    logic       gpio_o, ref_strobe, sec_tick;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pat_k = 0;
    bit done = 0;

    // model state
    bit h0, h1, h2, h3, v0, v1, v2, v3;
    bit ls;
    int mcnt, effp, eff;
    bit clr, exp_tick, cur_v, cur_l;

    assign rec_clk = {rc2, rc1, rc0};
    assign pin_clk = {pc2, pc1, pc0};

    refgen_8k #(.DIV_DS3(D0), .DIV_E3(D1), .DIV_STS1(D2), .SEC_STROBES(NS)) uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sel(sel),
        .ref_in_sel(ref_in_sel), .ref_out_sel(ref_out_sel), .clk_rec_en(clk_rec_en),
        .rec_clk(rec_clk), .pin_clk(pin_clk), .port_ref(port_ref), .ext_ref(ext_ref),
        .gpio_alt(gpio_alt), .gpio_o(gpio_o), .ref_strobe(ref_strobe), .sec_tick(sec_tick)
    );

    always #5 clk = ~clk;
    // line clocks: periods are multiples of 10 ns, offset 2 ns from time zero
    initial begin #2; forever #10 pc0 = ~pc0; end   // 20 ns
    initial begin #2; forever #15 pc1 = ~pc1; end   // 30 ns
    initial begin #2; forever #20 pc2 = ~pc2; end   // 40 ns
    initial begin #2; forever #20 rc0 = ~rc0; end   // 40 ns
    initial begin #2; forever #10 rc1 = ~rc1; end   // 20 ns
    initial begin #2; forever #10 rc2 = ~rc2; end   // 20 ns

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, expv);
        end
    endtask

    // cycle-by-cycle reference model, evaluated at each falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            h0 = 0; h1 = 0; h2 = 0; h3 = 0;
            v0 = 1; v1 = 1; v2 = 1; v3 = 1;
            ls = 0; mcnt = 0; effp = 0;
        end else if (!done) begin
            eff = ref_in_sel ? 8 : int'(sel);
            clr = soft_rst || (eff == 0) || (eff != effp);
            exp_tick = !clr && ls && (mcnt == NS - 1);
            chk(sec_tick == exp_tick, clr ? "R7 tick" : "R6 tick", sec_tick, exp_tick);
            if (clr) mcnt = 0;
            else if (ls) mcnt = (mcnt == NS - 1) ? 0 : mcnt + 1;
            effp = soft_rst ? 0 : eff;

            if (ref_in_sel) begin cur_v = 1; cur_l = ext_ref; end
            else if (sel == 3'd0) begin cur_v = 1; cur_l = 0; end
            else if (sel[2]) begin cur_v = 1; cur_l = port_ref[sel[1:0]]; end
            else begin cur_v = 0; cur_l = 0; end

            h3 = h2; v3 = v2; h2 = h1; v2 = v1; h1 = h0; v1 = v0; h0 = cur_l; v0 = cur_v;
            if (soft_rst) begin
                h0 = 0; h1 = 0; h2 = 0; v0 = 1; v1 = 1; v2 = 1;
                chk(ref_strobe == 1'b0, "R9 strobe", ref_strobe, 0);
            end else if (v2 && v3) begin
                chk(ref_strobe == (h2 && !h3),
                    (eff == 0) ? "R2 strobe" : (eff == 8) ? "R5 strobe" : "R4 strobe",
                    ref_strobe, (h2 && !h3));
            end
            chk(gpio_o == (ref_out_sel ? ref_strobe : gpio_alt), "R8 pin",
                gpio_o, (ref_out_sel ? ref_strobe : gpio_alt));
            ls = ref_strobe;
        end
    end

    task automatic run_pat(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); #1;
            pat_k++;
            for (int i = 0; i < 4; i++) port_ref[i] = ((pat_k / (i + 2)) % 2) == 1;
            ext_ref  = ((pat_k / 5) % 2) == 1;
            gpio_alt = ((pat_k / 3) % 2) == 1;
        end
    endtask

    task automatic set_ctrl(input bit ovr, input logic [2:0] s);
        @(negedge clk); #1;
        ref_in_sel = ovr;
        sel = s;
    endtask

    task automatic wait_strobe(output int t);
        t = -1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (ref_strobe) begin
                t = cyc;
                return;
            end
        end
    endtask

    task automatic measure(input int expi, input string tag);
        int t0, t1;
        wait_strobe(t0);
        wait_strobe(t0);
        for (int k = 0; k < 3; k++) begin
            wait_strobe(t1);
            chk(t0 >= 0 && t1 >= 0 && (t1 - t0) == expi, tag, t1 - t0, expi);
            t0 = t1;
        end
    endtask

    initial begin
        int cnt;
        repeat (4) @(negedge clk);
        chk(ref_strobe == 1'b0, "R1 strobe in reset", ref_strobe, 0);
        chk(sec_tick == 1'b0, "R1 tick in reset", sec_tick, 0);
        chk(gpio_o == gpio_alt, "R1 pin in reset", gpio_o, gpio_alt);
        @(negedge clk); #1;
        rst_n = 1'b1;

        // R2: idle code with busy inputs
        run_pat(40);

        // R4 / R6 / R7: each port source, switches clear the counter
        for (int s = 4; s < 8; s++) begin
            set_ctrl(1'b0, 3'(s));
            run_pat(50);
        end

        // R8: strobe on the shared pin
        @(negedge clk); #1; ref_out_sel = 1'b1;
        set_ctrl(1'b0, 3'd4);
        run_pat(40);
        @(negedge clk); #1; ref_out_sel = 1'b0;

        // R5: override beats the select code, including 000
        set_ctrl(1'b1, 3'd5);
        run_pat(60);
        set_ctrl(1'b1, 3'd0);
        run_pat(40);
        set_ctrl(1'b0, 3'd4);
        run_pat(40);

        // R10: a level held high gives one strobe
        @(negedge clk); #1; port_ref = 4'd0; ext_ref = 1'b0;
        repeat (6) @(negedge clk);
        #1; port_ref[0] = 1'b1;
        cnt = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (ref_strobe) cnt++;
        end
        chk(cnt == 1, "R10 single strobe", cnt, 1);
        @(negedge clk); #1; port_ref = 4'd0;

        // R3: divided line clocks, pin and recovered
        set_ctrl(1'b0, 3'd1);
        measure(D0 * 2, "R3 div0 pin");
        set_ctrl(1'b0, 3'd2);
        measure(D1 * 3, "R3 div1 pin");
        set_ctrl(1'b0, 3'd3);
        measure(D2 * 4, "R3 div2 pin");
        @(negedge clk); #1; clk_rec_en = 1'b1;
        set_ctrl(1'b0, 3'd1);
        measure(D0 * 4, "R3 div0 recovered");
        @(negedge clk); #1; clk_rec_en = 1'b0;
        measure(D0 * 2, "R3 div0 pin again");

        // R9: soft reset held, then divided strobes resume
        @(negedge clk); #1; soft_rst = 1'b1;
        repeat (12) @(negedge clk);
        #1; soft_rst = 1'b0;
        measure(D0 * 2, "R9 resume period");

        repeat (5) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule